// File: doc/BRIEF.md
# Byte-Load and Preload Instruction Decoder

This block turns one 32-bit instruction word, already known to belong to the byte-load and memory-hint encoding group, into a decoded record. The record gives the operation kind, the addressing mode, the three register indices, the direction of the offset, the writeback flag, the immediate and the register shift amount. Two register indices carry special meaning. A base index of 15 selects program-counter-relative literal forms. A destination index of 15 turns a load into a cache hint. A three-bit field in bits 10:8 holds pre-index, add and writeback flags, and it picks among the indexed variants.

Words come in on a valid/ready handshake. The decoded record sits in a one-entry output register, which a two-state controller manages. In state ST_EMPTY, nothing is held and the block always accepts a word. In state ST_FULL, a record is presented downstream. The controller uses these transitions:

- IDLE: stay in ST_EMPTY when no word arrives.
- LOAD: go from ST_EMPTY to ST_FULL when a word is taken.
- HOLD: stay in ST_FULL when the consumer stalls.
- REFILL: stay in ST_FULL when the held record leaves and a new word is taken in the same cycle.
- DRAIN: go from ST_FULL to ST_EMPTY when the record leaves and no new word arrives.

Reset forces ST_EMPTY.

Top module: `byte_load_decoder`

## Requirements
- R1: `out_kind` encodes the operation as follows: 0 undefined, 1 zero-extending byte load, 2 sign-extending byte load, 3 unprivileged zero-extending load, 4 unprivileged sign-extending load, 5 data preload, 6 data preload for write, 7 instruction preload. `out_mode` encodes the addressing mode as follows: 0 none, 1 literal, 2 immediate offset, 3 register offset, 4 pre-indexed, 5 post-indexed.
- R2: `out_base`, `out_dest` and `out_index` always carry word bits 19:16, 15:12 and 3:0 respectively, whatever the kind.
- R3: When bits 19:16 equal 15, the mode is literal, the immediate is bits 11:0, add equals bit 23 and writeback is 0. The kind then depends on bits 15:12 and bit 24:
  - If bits 15:12 equal 15, the kind is 7 when bit 24 is set and 5 otherwise.
  - Otherwise, the kind is 2 when bit 24 is set and 1 otherwise.
- R4: When bits 15:12 equal 15 and bits 19:16 do not, the word is a hint. Call the group field bits 24:23.
  - With a group of 0 or 1, the kind is 6 if bit 21 is set and 5 otherwise.
  - With a group of 2 or 3, the kind is 7.
  - Writeback is never set for a hint.
- R5: With a group of 0 or 2 and bits 11:6 all zero, the mode is register offset, add is 1, the shift amount is bits 5:4 and the immediate is 0.
- R6: With a group of 1 or 3 and base not 15, the mode is immediate offset, add is 1 and the immediate is bits 11:0. Bit 24 selects a signed load, or an instruction preload when the destination is 15.
- R7: For a load with base not 15 and a group of 0 or 2, bits 11:8 equal to 1110 give an unprivileged load (kind 3 or 4, by bit 24) with immediate mode, add 1 and the immediate equal to bits 7:0 zero-extended.
- R8: For the same loads, when bits 11 and 8 are both set, or bits 11:8 equal 1100, bits 10:8 are read as pre-index (bit 10), add (bit 9) and writeback (bit 8). The immediate is bits 7:0, and the values map as follows:
  - 1 gives post-indexed, subtract, writeback.
  - 3 gives post-indexed, add, writeback.
  - 4 gives immediate offset, subtract, no writeback.
  - 5 gives pre-indexed, subtract, writeback.
  - 7 gives pre-indexed, add, writeback.
  - Any other value is undefined.
- R9: For a hint with a group of 0 or 2 and bits 11:8 equal to 1100, the mode is immediate offset, add is 0 and the immediate is bits 7:0.
- R10: Any word that no rule above covers decodes as kind 0 with mode 0, add 0, writeback 0, immediate 0 and shift amount 0.
- R11: `in_ready` is high when no record is held or when `out_ready` is high. A word taken on a valid-and-ready cycle appears at the outputs with `out_valid` high after that clock edge. With no new word, a consumed record leaves `out_valid` low.
- R12: While `out_valid` is high and `out_ready` is low, every decoded output stays unchanged and `in_ready` is low.
- R13: A synchronous reset clears `out_valid`, including while a record is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction word offered |
| in_ready | output | 1 | Decoder can take a word this cycle |
| in_word | input | 32 | Instruction word |
| out_ready | input | 1 | Consumer takes the held record |
| out_valid | output | 1 | A decoded record is held |
| out_kind | output | 3 | Operation kind (R1) |
| out_mode | output | 3 | Addressing mode (R1) |
| out_base | output | 4 | Base register index |
| out_dest | output | 4 | Destination register index |
| out_index | output | 4 | Offset register index |
| out_add | output | 1 | Offset is added (1) or subtracted (0) |
| out_wback | output | 1 | Base register is written back |
| out_imm | output | 12 | Immediate offset, zero-extended |
| out_shamt | output | 2 | Left shift applied to the offset register |

## Verification
The bench builds the block with its default and only meaningful configuration. The field widths are set by the fixed instruction format and kept as package constants, so every register index, including the reserved value 15 in both the base and destination positions, can be driven. With these widths, the vector table covers every kind, every addressing mode and every legal value of the index/add/writeback field, plus several near-miss encodings that must fall through to undefined. Directed steps then exercise the HOLD, REFILL and DRAIN transitions and a reset that arrives while a record is held.

// File: rtl/bld_pkg.sv
package bld_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned REG_W  = 4;
    localparam int unsigned IMM_W  = 12;
    localparam int unsigned SH_W   = 2;
    localparam int unsigned KIND_W = 3;
    localparam int unsigned MODE_W = 3;

    typedef enum logic [KIND_W-1:0] {
        K_UNDEF    = 3'd0,
        K_LD_ZX    = 3'd1,
        K_LD_SX    = 3'd2,
        K_LDU_ZX   = 3'd3,
        K_LDU_SX   = 3'd4,
        K_PF_DATA  = 3'd5,
        K_PF_WRITE = 3'd6,
        K_PF_INSN  = 3'd7
    } kind_e;

    typedef enum logic [MODE_W-1:0] {
        AM_NONE    = 3'd0,
        AM_LITERAL = 3'd1,
        AM_IMM     = 3'd2,
        AM_REG     = 3'd3,
        AM_PRE     = 3'd4,
        AM_POST    = 3'd5
    } amode_e;

    typedef struct packed {
        kind_e              kind;
        amode_e             mode;
        logic [REG_W-1:0]   base;
        logic [REG_W-1:0]   dest;
        logic [REG_W-1:0]   index;
        logic               add;
        logic               wback;
        logic [IMM_W-1:0]   imm;
        logic [SH_W-1:0]    shamt;
    } dec_t;

    localparam int unsigned DEC_W = $bits(dec_t);

endpackage

// File: rtl/bld_classify.sv
module bld_classify
    import bld_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output dec_t              dec
);
    localparam logic [REG_W-1:0] PC_IDX   = REG_W'((1 << REG_W) - 1);
    localparam int unsigned      NARROW_W = 8;

    logic [1:0]          grp;
    logic [5:0]          sub;
    logic [2:0]          pwb;
    logic                base_pc;
    logic                dest_pc;
    logic [IMM_W-1:0]    imm_wide;
    logic [IMM_W-1:0]    imm_narrow;
    logic                unused_bits;

    assign grp        = word[24:23];
    assign sub        = word[11:6];
    assign pwb        = word[10:8];
    assign base_pc    = (word[19:16] == PC_IDX);
    assign dest_pc    = (word[15:12] == PC_IDX);
    assign imm_wide   = word[IMM_W-1:0];
    assign imm_narrow = IMM_W'(word[NARROW_W-1:0]);
    assign unused_bits = ^{word[31:25], word[22], word[20]};

    always_comb begin
        dec        = '0;
        dec.kind   = K_UNDEF;
        dec.mode   = AM_NONE;
        dec.base   = word[19:16];
        dec.dest   = word[15:12];
        dec.index  = word[3:0];
        if (base_pc) begin
            dec.mode = AM_LITERAL;
            dec.add  = word[23];
            dec.imm  = imm_wide;
            if (dest_pc) dec.kind = grp[1] ? K_PF_INSN : K_PF_DATA;
            else         dec.kind = grp[1] ? K_LD_SX   : K_LD_ZX;
        end else if (dest_pc) begin
            if (grp[0]) begin
                dec.kind = grp[1] ? K_PF_INSN : (word[21] ? K_PF_WRITE : K_PF_DATA);
                dec.mode = AM_IMM;
                dec.add  = 1'b1;
                dec.imm  = imm_wide;
            end else if (sub == 6'd0) begin
                dec.kind  = grp[1] ? K_PF_INSN : (word[21] ? K_PF_WRITE : K_PF_DATA);
                dec.mode  = AM_REG;
                dec.add   = 1'b1;
                dec.shamt = word[5:4];
            end else if (sub[5:2] == 4'hC) begin
                dec.kind = grp[1] ? K_PF_INSN : (word[21] ? K_PF_WRITE : K_PF_DATA);
                dec.mode = AM_IMM;
                dec.add  = 1'b0;
                dec.imm  = imm_narrow;
            end
        end else begin
            if (grp[0]) begin
                dec.kind = grp[1] ? K_LD_SX : K_LD_ZX;
                dec.mode = AM_IMM;
                dec.add  = 1'b1;
                dec.imm  = imm_wide;
            end else if (sub == 6'd0) begin
                dec.kind  = grp[1] ? K_LD_SX : K_LD_ZX;
                dec.mode  = AM_REG;
                dec.add   = 1'b1;
                dec.shamt = word[5:4];
            end else if (sub[5:2] == 4'hE) begin
                dec.kind = grp[1] ? K_LDU_SX : K_LDU_ZX;
                dec.mode = AM_IMM;
                dec.add  = 1'b1;
                dec.imm  = imm_narrow;
            end else if ((sub[5] && sub[2]) || (sub[5:2] == 4'hC)) begin
                case (pwb)
                    3'd1, 3'd3: begin
                        dec.kind  = grp[1] ? K_LD_SX : K_LD_ZX;
                        dec.mode  = AM_POST;
                        dec.add   = pwb[1];
                        dec.wback = 1'b1;
                        dec.imm   = imm_narrow;
                    end
                    3'd4: begin
                        dec.kind  = grp[1] ? K_LD_SX : K_LD_ZX;
                        dec.mode  = AM_IMM;
                        dec.add   = 1'b0;
                        dec.imm   = imm_narrow;
                    end
                    3'd5, 3'd7: begin
                        dec.kind  = grp[1] ? K_LD_SX : K_LD_ZX;
                        dec.mode  = AM_PRE;
                        dec.add   = pwb[1];
                        dec.wback = 1'b1;
                        dec.imm   = imm_narrow;
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/bld_hold_reg.sv
module bld_hold_reg #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              up_valid,
    output logic              up_ready,
    input  logic [DATA_W-1:0] up_data,
    output logic              dn_valid,
    input  logic              dn_ready,
    output logic [DATA_W-1:0] dn_data
);
    typedef enum logic [0:0] {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } hold_state_e;

    hold_state_e       state_q;
    hold_state_e       state_d;
    logic              take;
    logic [DATA_W-1:0] data_q;

    assign up_ready = (state_q == ST_EMPTY) || dn_ready;
    assign take     = up_valid && up_ready;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (take) state_d = ST_FULL;              // LOAD, else IDLE
            ST_FULL:  if (dn_ready && !take) state_d = ST_EMPTY; // DRAIN, else HOLD/REFILL
            default:  state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_EMPTY;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (take) data_q <= up_data;
    end

    assign dn_valid = (state_q == ST_FULL);
    assign dn_data  = data_q;

    // R11
    accept_chk: assert property (@(posedge clk) disable iff (rst)
        up_valid && up_ready |=> dn_valid && (dn_data == $past(up_data)));

    // R12
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        dn_valid && !dn_ready |=> dn_valid && $stable(dn_data));

endmodule

// File: rtl/byte_load_decoder.sv
module byte_load_decoder
    import bld_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_word,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [KIND_W-1:0] out_kind,
    output logic [MODE_W-1:0] out_mode,
    output logic [REG_W-1:0]  out_base,
    output logic [REG_W-1:0]  out_dest,
    output logic [REG_W-1:0]  out_index,
    output logic              out_add,
    output logic              out_wback,
    output logic [IMM_W-1:0]  out_imm,
    output logic [SH_W-1:0]   out_shamt
);
    localparam logic [REG_W-1:0] PC_IDX = REG_W'((1 << REG_W) - 1);

    dec_t             dec_now;
    logic [DEC_W-1:0] held_bits;
    dec_t             held;

    bld_classify u_classify (
        .word (in_word),
        .dec  (dec_now)
    );

    bld_hold_reg #(.DATA_W(DEC_W)) u_hold (
        .clk      (clk),
        .rst      (rst),
        .up_valid (in_valid),
        .up_ready (in_ready),
        .up_data  (dec_now),
        .dn_valid (out_valid),
        .dn_ready (out_ready),
        .dn_data  (held_bits)
    );

    assign held      = dec_t'(held_bits);
    assign out_kind  = held.kind;
    assign out_mode  = held.mode;
    assign out_base  = held.base;
    assign out_dest  = held.dest;
    assign out_index = held.index;
    assign out_add   = held.add;
    assign out_wback = held.wback;
    assign out_imm   = held.imm;
    assign out_shamt = held.shamt;

    // R4
    pref_nowb_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && (out_kind >= KIND_W'(K_PF_DATA)) |-> !out_wback);

    // R8
    post_wb_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && (out_mode == MODE_W'(AM_POST)) |-> out_wback);

    // R3
    literal_base_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && (out_mode == MODE_W'(AM_LITERAL)) |-> (out_base == PC_IDX) && !out_wback);

    // R10
    undef_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && (out_kind == KIND_W'(K_UNDEF)) |->
        (out_mode == MODE_W'(AM_NONE)) && !out_add && !out_wback && (out_imm == '0) && (out_shamt == '0));

endmodule

// File: tb/byte_load_decoder_tb_top.sv
module byte_load_decoder_tb_top;

    typedef struct packed {
        logic [31:0] word;
        logic [2:0]  kind;
        logic [2:0]  mode;
        logic        add;
        logic        wb;
        logic [11:0] imm;
        logic [1:0]  sh;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 28;
    localparam vec_t VECS [NV] = '{
        '{32'hF81F3123, 3'd1, 3'd1, 1'b0, 1'b0, 12'h123, 2'd0, 4'd3},  // R3 literal zx subtract
        '{32'hF99F50FF, 3'd2, 3'd1, 1'b1, 1'b0, 12'h0FF, 2'd0, 4'd3},  // R3 literal sx add
        '{32'hF89FFABC, 3'd5, 3'd1, 1'b1, 1'b0, 12'hABC, 2'd0, 4'd3},  // R3 literal data preload
        '{32'hF91FF001, 3'd7, 3'd1, 1'b0, 1'b0, 12'h001, 2'd0, 4'd3},  // R3 literal insn preload
        '{32'hF8124037, 3'd1, 3'd3, 1'b1, 1'b0, 12'h000, 2'd3, 4'd5},  // R5 reg offset zx
        '{32'hF919101A, 3'd2, 3'd3, 1'b1, 1'b0, 12'h000, 2'd1, 4'd5},  // R5 reg offset sx
        '{32'hF8936FFF, 3'd1, 3'd2, 1'b1, 1'b0, 12'hFFF, 2'd0, 4'd6},  // R6 imm12 zx
        '{32'hF9900800, 3'd2, 3'd2, 1'b1, 1'b0, 12'h800, 2'd0, 4'd6},  // R6 imm12 sx
        '{32'hF8145E3C, 3'd3, 3'd2, 1'b1, 1'b0, 12'h03C, 2'd0, 4'd7},  // R7 user zx
        '{32'hF9112E7F, 3'd4, 3'd2, 1'b1, 1'b0, 12'h07F, 2'd0, 4'd7},  // R7 user sx
        '{32'hF8167910, 3'd1, 3'd5, 1'b0, 1'b1, 12'h010, 2'd0, 4'd8},  // R8 field 1
        '{32'hF9189B22, 3'd2, 3'd5, 1'b1, 1'b1, 12'h022, 2'd0, 4'd8},  // R8 field 3
        '{32'hF81ABC44, 3'd1, 3'd2, 1'b0, 1'b0, 12'h044, 2'd0, 4'd8},  // R8 field 4
        '{32'hF91CDD55, 3'd2, 3'd4, 1'b0, 1'b1, 12'h055, 2'd0, 4'd8},  // R8 field 5
        '{32'hF81E0F66, 3'd1, 3'd4, 1'b1, 1'b1, 12'h066, 2'd0, 4'd8},  // R8 field 7
        '{32'hF812F021, 3'd5, 3'd3, 1'b1, 1'b0, 12'h000, 2'd2, 4'd4},  // R4 data preload reg
        '{32'hF833F005, 3'd6, 3'd3, 1'b1, 1'b0, 12'h000, 2'd0, 4'd4},  // R4 write preload reg
        '{32'hF834FC7F, 3'd6, 3'd2, 1'b0, 1'b0, 12'h07F, 2'd0, 4'd9},  // R9 write preload sub
        '{32'hF895F123, 3'd5, 3'd2, 1'b1, 1'b0, 12'h123, 2'd0, 4'd4},  // R4 data preload imm12
        '{32'hF8B6F456, 3'd6, 3'd2, 1'b1, 1'b0, 12'h456, 2'd0, 4'd4},  // R4 write preload imm12
        '{32'hF917F03B, 3'd7, 3'd3, 1'b1, 1'b0, 12'h000, 2'd3, 4'd4},  // R4 insn preload reg
        '{32'hF918FC09, 3'd7, 3'd2, 1'b0, 1'b0, 12'h009, 2'd0, 4'd9},  // R9 insn preload sub
        '{32'hF999FABC, 3'd7, 3'd2, 1'b1, 1'b0, 12'hABC, 2'd0, 4'd6},  // R6 insn preload imm12
        '{32'hF8112040, 3'd0, 3'd0, 1'b0, 1'b0, 12'h000, 2'd0, 4'd10}, // R10 load sub 000001
        '{32'hF8112800, 3'd0, 3'd0, 1'b0, 1'b0, 12'h000, 2'd0, 4'd10}, // R10 load sub 100000
        '{32'hF813F910, 3'd0, 3'd0, 1'b0, 1'b0, 12'h000, 2'd0, 4'd10}, // R10 hint post form
        '{32'hF912FE00, 3'd0, 3'd0, 1'b0, 1'b0, 12'h000, 2'd0, 4'd10}, // R10 hint user form
        '{32'hF9111100, 3'd0, 3'd0, 1'b0, 1'b0, 12'h000, 2'd0, 4'd10}  // R10 load sub 000100
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic        in_ready;
    logic [31:0] in_word;
    logic        out_ready;
    logic        out_valid;
    logic [2:0]  out_kind;
    logic [2:0]  out_mode;
    logic [3:0]  out_base;
    logic [3:0]  out_dest;
    logic [3:0]  out_index;
    logic        out_add;
    logic        out_wback;
    logic [11:0] out_imm;
    logic [1:0]  out_shamt;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    byte_load_decoder dut_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_word   (in_word),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_kind  (out_kind),
        .out_mode  (out_mode),
        .out_base  (out_base),
        .out_dest  (out_dest),
        .out_index (out_index),
        .out_add   (out_add),
        .out_wback (out_wback),
        .out_imm   (out_imm),
        .out_shamt (out_shamt)
    );

    function automatic logic [34:0] expect_of(vec_t v);
        return {1'b1, v.kind, v.mode, v.word[19:16], v.word[15:12], v.word[3:0],
                v.add, v.wb, v.imm, v.sh};
    endfunction

    function automatic logic [34:0] actual_now();
        return {out_valid, out_kind, out_mode, out_base, out_dest, out_index,
                out_add, out_wback, out_imm, out_shamt};
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    initial begin
        rst       = 1'b1;
        in_valid  = 1'b0;
        in_word   = '0;
        out_ready = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R13 reset state, R11 ready when empty
        check(out_valid == 1'b0, "R13", 64'(out_valid), 64'd0);
        check(in_ready == 1'b1, "R11", 64'(in_ready), 64'd1);

        // Table walk: R1 encodings and R2 register fields checked on every vector
        for (int i = 0; i < NV; i++) begin
            in_valid  = 1'b1;
            in_word   = VECS[i].word;
            out_ready = 1'b1;
            @(posedge clk);
            @(negedge clk);
            check(actual_now() == expect_of(VECS[i]), $sformatf("R%0d vec%0d", VECS[i].req, i),
                  64'(actual_now()), 64'(expect_of(VECS[i])));
        end

        // R11 DRAIN: no new word, consumed record leaves
        in_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b0, "R11 drain", 64'(out_valid), 64'd0);

        // R12 HOLD: load vec 6 with consumer stalled
        out_ready = 1'b0;
        in_valid  = 1'b1;
        in_word   = VECS[6].word;
        @(posedge clk);
        @(negedge clk);
        check(in_ready == 1'b0, "R12 ready low", 64'(in_ready), 64'd0);
        in_word = VECS[13].word;
        @(posedge clk);
        @(negedge clk);
        check(actual_now() == expect_of(VECS[6]), "R12 held", 64'(actual_now()), 64'(expect_of(VECS[6])));
        @(posedge clk);
        @(negedge clk);
        check(actual_now() == expect_of(VECS[6]), "R12 held again", 64'(actual_now()), 64'(expect_of(VECS[6])));

        // R11 REFILL: release, new word taken while old leaves
        out_ready = 1'b1;
        #1;
        check(in_ready == 1'b1, "R11 ready on consume", 64'(in_ready), 64'd1);
        @(posedge clk);
        @(negedge clk);
        check(actual_now() == expect_of(VECS[13]), "R11 refill", 64'(actual_now()), 64'(expect_of(VECS[13])));

        // R13 reset while full
        out_ready = 1'b0;
        in_word   = VECS[0].word;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        rst      = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b0, "R13 reset while full", 64'(out_valid), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R13 stays empty", 64'(out_valid), 64'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule